// File: doc/BRIEF.md
# SPI Chip-Select Guard Timer

This block sequences the chip-select and serial-clock pins for one channel of an SPI master that drives chip select on its own. A start strobe pulls chip select low. The block then waits a programmable guard interval before the first serial-clock edge and runs the clock for the requested number of bits. After the last edge it waits the same guard interval before it releases chip select. Every timing step is measured in ticks of a half-period strobe that comes from the SPI clock reference.

The guard interval is chosen per transfer with a 2-bit code. It gives 0.5, 1.5, 2.5 or 3.5 serial-clock periods, which is 1, 3, 5 or 7 ticks. A bypass input removes both guard intervals, for a channel whose chip select is not generated automatically. A companion shifter follows the shift-enable output, which pulses once per bit. All pins are plain control and status. No data stream passes through this block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `spi_cs_timer`

## Requirements
- R1: While reset is asserted, and after any reset (including one during a transfer), cs_n_o is 1 and sclk_o, busy_o, done_o and shift_en_o are 0.
- R2: While idle, sclk_o follows cpol_i (0 idles low, 1 idles high). Serial-clock edges occur only while a transfer is active.
- R3: A start_i sampled high while idle drives cs_n_o low and busy_o high at the next clock edge.
- R4: With guard_off_i = 0, the first serial-clock edge occurs on the G-th tick after chip select falls. G is 1, 3, 5 or 7 for guard code 00, 01, 10 or 11. Clock edges occur only on ticks.
- R5: word_len_i holds the bit count minus one. A transfer produces exactly 2 × (word_len_i + 1) serial-clock edges.
- R6: shift_en_o pulses for one cycle exactly once per bit, in the cycle where sclk_o returns to its idle level.
- R7: With guard_off_i = 0, cs_n_o rises on the G-th tick after the last serial-clock edge, using the same G as R4.
- R8: With guard_off_i = 1, the first edge occurs on the first tick after chip select falls, and cs_n_o rises in the same cycle as the last edge.
- R9: After chip select rises, the block waits one more tick. It then returns to idle, clears busy_o and pulses done_o for exactly one cycle.
- R10: A start_i sampled while busy is ignored. Word length, polarity, guard code and bypass are taken only at the accepted start, so changing them during a transfer has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Half-period strobe of the SPI clock reference, one cycle wide |
| start_i | input | 1 | Request a transfer |
| word_len_i | input | LEN_W | Bits per word minus one |
| cpol_i | input | 1 | Serial-clock idle level |
| guard_code_i | input | 2 | Guard interval code (1/3/5/7 ticks) |
| guard_off_i | input | 1 | 1 = no guard intervals |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| shift_en_o | output | 1 | One pulse per bit for the companion shifter |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse on return to idle |

## Verification
A table of transfers mixes all four guard codes, both polarities, word lengths of 1, 2, 4, 5, 8 and 16 bits, and the bypass setting. The bench counts ticks from the chip-select fall to the first edge and from the last edge to the chip-select rise. These counts separate the four guard codes from one another and separate bypass from code 00. Counting edges and shift pulses for each length exposes off-by-one errors in the bit counter. Running the same length under both polarities confirms that shift pulses follow the idle level and not a fixed level. A directed test changes every setting and strobes start in the middle of a transfer, and must see the original timing unchanged and no second transfer. A second directed test applies reset during the clock phase.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_RELEASE
  } cs_state_e;

  localparam int GUARD_CODE_W = 2;
  localparam int GUARD_CNT_W  = GUARD_CODE_W + 1;

  // guard code c maps to 2c+1 half-period ticks: 1, 3, 5, 7
  function automatic logic [GUARD_CNT_W-1:0] guard_ticks(input logic [GUARD_CODE_W-1:0] code);
    return {code, 1'b1};
  endfunction

endpackage

// File: rtl/spi_cs_guard_cnt.sv
module spi_cs_guard_cnt
  import spi_cs_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    capture_i,
  input  logic [GUARD_CODE_W-1:0] code_i,
  input  logic                    reload_i,
  input  logic                    dec_i,
  output logic                    one_left_o
);

  logic [GUARD_CODE_W-1:0] code_q;
  logic [GUARD_CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      cnt_q  <= '0;
    end else if (capture_i) begin
      code_q <= code_i;
      cnt_q  <= guard_ticks(code_i);
    end else if (reload_i) begin
      cnt_q  <= guard_ticks(code_q);
    end else if (dec_i && cnt_q != '0) begin
      cnt_q  <= cnt_q - GUARD_CNT_W'(1);
    end
  end

  assign one_left_o = (cnt_q == GUARD_CNT_W'(1));

endmodule

// File: rtl/spi_cs_edge_gen.sv
module spi_cs_edge_gen #(
  parameter int LEN_W  = 4,
  parameter int EDGE_W = LEN_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             track_i,
  input  logic             cpol_i,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_code_i,
  input  logic             step_i,
  output logic             sclk_o,
  output logic             last_o,
  output logic             shift_en_o
);

  logic [EDGE_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_o     <= 1'b0;
      left_q     <= '0;
      shift_en_o <= 1'b0;
    end else begin
      shift_en_o <= 1'b0;
      if (track_i) sclk_o <= cpol_i;
      if (load_i) begin
        left_q <= (EDGE_W'(len_code_i) + EDGE_W'(1)) << 1;
      end else if (step_i) begin
        sclk_o     <= ~sclk_o;
        left_q     <= left_q - EDGE_W'(1);
        // an odd count before the edge marks the second edge of a bit
        shift_en_o <= left_q[0];
      end
    end
  end

  assign last_o = (left_q == EDGE_W'(1));

endmodule

// File: rtl/spi_cs_fsm.sv
module spi_cs_fsm
  import spi_cs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic start_i,
  input  logic guard_off_i,
  input  logic guard_one_i,
  input  logic edge_last_i,
  output logic cs_n_o,
  output logic busy_o,
  output logic done_o,
  output logic capture_o,
  output logic reload_o,
  output logic dec_o,
  output logic track_o,
  output logic load_o,
  output logic step_o
);

  cs_state_e st_q;
  logic      bypass_q;

  always_comb begin
    track_o   = (st_q == ST_IDLE);
    capture_o = track_o && start_i;
    load_o    = capture_o;
    dec_o     = tick_i && (st_q == ST_LEAD || st_q == ST_TRAIL);
    step_o    = tick_i && ((st_q == ST_LEAD && guard_one_i) || st_q == ST_SHIFT);
    reload_o  = tick_i && (st_q == ST_SHIFT) && edge_last_i && !bypass_q;
    busy_o    = (st_q != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cs_n_o   <= 1'b1;
      done_o   <= 1'b0;
      bypass_q <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          bypass_q <= guard_off_i;
          cs_n_o   <= 1'b0;
          st_q     <= guard_off_i ? ST_SHIFT : ST_LEAD;
        end
        ST_LEAD: if (tick_i && guard_one_i) st_q <= ST_SHIFT;
        ST_SHIFT: if (tick_i && edge_last_i) begin
          if (bypass_q) begin
            cs_n_o <= 1'b1;
            st_q   <= ST_RELEASE;
          end else begin
            st_q   <= ST_TRAIL;
          end
        end
        ST_TRAIL: if (tick_i && guard_one_i) begin
          cs_n_o <= 1'b1;
          st_q   <= ST_RELEASE;
        end
        ST_RELEASE: if (tick_i) begin
          done_o <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_cs_timer.sv
module spi_cs_timer
  import spi_cs_pkg::*;
#(
  parameter int MAX_BITS = 16,
  parameter int LEN_W    = $clog2(MAX_BITS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_i,
  input  logic                    start_i,
  input  logic [LEN_W-1:0]        word_len_i,
  input  logic                    cpol_i,
  input  logic [GUARD_CODE_W-1:0] guard_code_i,
  input  logic                    guard_off_i,
  output logic                    cs_n_o,
  output logic                    sclk_o,
  output logic                    shift_en_o,
  output logic                    busy_o,
  output logic                    done_o
);

  localparam int EDGE_W = LEN_W + 2;

  logic capture, reload, dec, track, load, step;
  logic guard_one, edge_last;

  spi_cs_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .start_i     (start_i),
    .guard_off_i (guard_off_i),
    .guard_one_i (guard_one),
    .edge_last_i (edge_last),
    .cs_n_o      (cs_n_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .capture_o   (capture),
    .reload_o    (reload),
    .dec_o       (dec),
    .track_o     (track),
    .load_o      (load),
    .step_o      (step)
  );

  spi_cs_guard_cnt u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_i  (capture),
    .code_i     (guard_code_i),
    .reload_i   (reload),
    .dec_i      (dec),
    .one_left_o (guard_one)
  );

  spi_cs_edge_gen #(
    .LEN_W  (LEN_W),
    .EDGE_W (EDGE_W)
  ) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .track_i    (track),
    .cpol_i     (cpol_i),
    .load_i     (load),
    .len_code_i (word_len_i),
    .step_i     (step),
    .sclk_o     (sclk_o),
    .last_o     (edge_last),
    .shift_en_o (shift_en_o)
  );

endmodule

// File: rtl/spi_cs_timer_chk.sv
module spi_cs_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_i,
  input logic cs_n_o,
  input logic sclk_o,
  input logic shift_en_o,
  input logic busy_o,
  input logic done_o
);

  // R2: no clock movement while chip select is high unless idle
  p_quiet_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_o && $past(cs_n_o) && !$stable(sclk_o)) |-> !busy_o);

  // R3: chip select low implies an active transfer
  p_cs_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> busy_o);

  // R4: edges during a transfer follow a tick
  p_edge_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_o) && !$stable(sclk_o)) |-> $past(tick_i));

  // R6: shift enable coincides with a clock edge
  p_shift_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en_o |-> !$stable(sclk_o));

  // R9: done is a single-cycle pulse seen in idle with chip select released
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cs_n_o && !busy_o));

  // R10: chip select falls only from idle
  p_start_from_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> !$past(busy_o));

endmodule

bind spi_cs_timer spi_cs_timer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .cs_n_o     (cs_n_o),
  .sclk_o     (sclk_o),
  .shift_en_o (shift_en_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/spi_cs_timer_tb.sv
module spi_cs_timer_tb;
  localparam int MAX_BITS = 16;
  localparam int LEN_W    = 4;
  localparam int TICK_DIV = 3;
  localparam int NVEC     = 7;
  // fields: len[15:12] cpol[11] code[10:9] bypass[8] lead[7:4] trail[3:0]
  localparam logic [15:0] VEC [0:NVEC-1] = '{
    {4'd7,  1'b0, 2'd0, 1'b0, 4'd1, 4'd1},
    {4'd7,  1'b1, 2'd1, 1'b0, 4'd3, 4'd3},
    {4'd0,  1'b0, 2'd2, 1'b0, 4'd5, 4'd5},
    {4'd15, 1'b1, 2'd3, 1'b0, 4'd7, 4'd7},
    {4'd3,  1'b0, 2'd3, 1'b1, 4'd1, 4'd0},
    {4'd4,  1'b1, 2'd2, 1'b1, 4'd1, 4'd0},
    {4'd1,  1'b1, 2'd0, 1'b0, 4'd1, 4'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0, tick_i = 1'b0, start_i = 1'b0;
  logic cpol_i = 1'b0, guard_off_i = 1'b0;
  logic [1:0] guard_code_i = '0;
  logic [LEN_W-1:0] word_len_i = '0;
  logic cs_n_o, sclk_o, shift_en_o, busy_o, done_o;

  spi_cs_timer #(.MAX_BITS(MAX_BITS)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .start_i(start_i),
    .word_len_i(word_len_i), .cpol_i(cpol_i), .guard_code_i(guard_code_i),
    .guard_off_i(guard_off_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
    .shift_en_o(shift_en_o), .busy_o(busy_o), .done_o(done_o)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, div_cnt = 0;
  logic prev_tick;
  int m_lead, m_edges, m_shifts, m_trail, m_rel, m_badlvl;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    prev_tick = tick_i;
    div_cnt = (div_cnt + 1) % TICK_DIV;
    tick_i = (div_cnt == 0);
  endtask

  task automatic run_xfer(input logic [3:0] len, input logic cp, input logic [1:0] code,
                          input logic bp, input bit inject);
    int phase, lead, trail, rel, edges;
    bit fin, injected;
    logic last_s;
    word_len_i = len; cpol_i = cp; guard_code_i = code; guard_off_i = bp;
    cycle(); cycle();
    check("R2 idle level", sclk_o, cp);
    start_i = 1'b1;
    cycle();
    start_i = 1'b0;
    check("R3 cs_n after start", cs_n_o, 0);
    check("R3 busy after start", busy_o, 1);
    phase = 1; lead = 0; trail = 0; rel = 0; edges = 0; fin = 0; injected = 0;
    m_lead = -1; m_trail = -1; m_shifts = 0; m_badlvl = 0; m_rel = -1;
    last_s = sclk_o;
    for (int i = 0; i < 3000 && !fin; i++) begin
      cycle();
      if (start_i) start_i = 1'b0;
      if (prev_tick) begin
        if (phase == 1) lead++;
        if (phase == 3) trail++;
        if (phase == 4) rel++;
      end
      if (sclk_o != last_s) begin
        edges++;
        last_s = sclk_o;
        if (phase == 1) begin m_lead = lead; phase = 2; end
        if (edges == 2 * (int'(len) + 1)) begin phase = 3; trail = 0; end
      end
      if (shift_en_o) begin
        m_shifts++;
        if (sclk_o != cp) m_badlvl++;
      end
      if (cs_n_o && phase == 3) begin m_trail = trail; phase = 4; rel = 0; end
      if (done_o) begin m_rel = rel; fin = 1; end
      if (inject && phase == 2 && edges == 2 && !injected) begin
        start_i = 1'b1; cpol_i = ~cp; guard_code_i = ~code;
        guard_off_i = ~bp; word_len_i = ~len; injected = 1;
      end
    end
    m_edges = edges;
    check("R9 watchdog transfer finished", int'(fin), 1);
    cycle();
    check("R9 done single cycle", done_o, 0);
    check("R9 busy cleared", busy_o, 0);
  endtask

  initial begin
    // R1: reset state
    cycle(); cycle();
    check("R1 cs_n in reset", cs_n_o, 1);
    check("R1 sclk in reset", sclk_o, 0);
    check("R1 busy in reset", busy_o, 0);
    check("R1 done in reset", done_o, 0);
    check("R1 shift_en in reset", shift_en_o, 0);
    rst_n = 1'b1;
    cycle();
    cpol_i = 1'b1;
    cycle(); cycle();
    check("R2 idle tracks polarity", sclk_o, 1);

    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] e;
      e = VEC[v];
      run_xfer(e[15:12], e[11], e[10:9], e[8], 1'b0);
      check(e[8] ? "R8 lead ticks" : "R4 lead ticks", m_lead, int'(e[7:4]));
      check("R5 edge count", m_edges, 2 * (int'(e[15:12]) + 1));
      check("R6 shift pulses", m_shifts, int'(e[15:12]) + 1);
      check("R6 shift at idle level", m_badlvl, 0);
      check(e[8] ? "R8 trail ticks" : "R7 trail ticks", m_trail, int'(e[3:0]));
      check("R9 release ticks", m_rel, 1);
    end

    // R10: start and new settings mid-transfer are ignored
    run_xfer(4'd5, 1'b0, 2'd2, 1'b0, 1'b1);
    check("R10 lead unchanged", m_lead, 5);
    check("R10 edges unchanged", m_edges, 12);
    check("R10 trail unchanged", m_trail, 5);
    begin
      int lows;
      lows = 0;
      for (int i = 0; i < 30; i++) begin
        cycle();
        if (!cs_n_o) lows++;
      end
      check("R10 no second transfer", lows, 0);
    end

    // R1: reset during the clock phase
    word_len_i = 4'd15; cpol_i = 1'b1; guard_code_i = 2'd0; guard_off_i = 1'b0;
    start_i = 1'b1;
    cycle();
    start_i = 1'b0;
    for (int i = 0; i < 12; i++) cycle();
    check("R1 busy before mid reset", busy_o, 1);
    rst_n = 1'b0;
    #1;
    check("R1 cs_n after mid reset", cs_n_o, 1);
    check("R1 busy after mid reset", busy_o, 0);
    check("R1 sclk after mid reset", sclk_o, 0);
    cycle();
    rst_n = 1'b1;
    cycle();
    check("R1 stays idle after reset", cs_n_o, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule